// File: doc/BRIEF.md
# Paged Register Serial Host Port

This block is a three-wire serial slave with a chip select. An external host uses it to reach a register space that is much larger than the address field of a single command. Each command carries a 5-bit register address. A 7-bit page pointer held inside the block supplies the upper address bits, which gives a 12-bit internal address. The page pointer can be written from any page through the top slot of the 32-slot window. It cannot be read back.

The serial pins are brought into the system clock domain through two-flop synchronisers. Edges of the serial clock are detected in that domain. A transfer is one command byte followed by a 24-bit data word, high byte first. Several transfers can follow one another inside one chip-select frame. Behind the serial logic, a request/acknowledge register bus reaches a register array. The array stands in for the datapath that is not part of this block. It has storage for a parameterised number of pages; all other pages read as zero and ignore writes. A sticky status output drops when a malformed command byte arrives, which warns the host that command framing may have been lost.

Top module: `paged_serial_host_if`

## Requirements
- R1: The host sends a command byte MSB first on `sdi`, and the block samples it on rising `sclk` edges. The byte is valid only when bit 7 = 0 and bit 0 = 0. Bit 6 = 1 means write and 0 means read, and bits 5:1 give the slot address. Commands can follow one another back to back inside one chip-select frame.
- R2: A write command is followed by 24 data bits, MSB first, sampled on rising `sclk`. They are stored at internal address {page, slot}, and a later read of that address returns them.
- R3: A read command is followed by 24 data bits on `sdo`, MSB first. `sdo` changes only after falling `sclk` edges. The first data bit is valid from the falling edge that follows the eighth command bit.
- R4: A write to slot 31 loads the page pointer from data bits 6:0, whatever page is current. Later slot accesses 0..30 go to that page.
- R5: After reset the page pointer is 0.
- R6: The page pointer is write-only, and a read of slot 31 returns 24 zero bits.
- R7: `cmd_ok` is 1 after reset. An invalid command byte drives it to 0, and it stays 0 until reset. No data phase follows an invalid byte, and the next 8 bits are taken as a new command.
- R8: `sdo_oe` is 0 whenever `cs_n` is high and 1 while it is low. Raising `cs_n` in the middle of a transfer discards that transfer, and the first byte of the next frame is taken as a command.
- R9: With a page pointer at or above the number of populated pages, writes change no storage and reads return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host, idles low |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| sdo_oe | output | 1 | Output enable for the `sdo` pad driver |
| cmd_ok | output | 1 | Sticky command-framing status, 1 = no invalid command seen |

## Verification
The bench aims at the page pointer first. Data written on page 0 before any page write must come back after an explicit return to page 0 and must be absent on page 1; a design that reset the pointer elsewhere, or used the slot bits in place of the page bits, would alias the two pages. It reads slot 31 to catch a pointer that leaks back through reads. It also accesses an unpopulated page, where a design with wrapped index arithmetic would corrupt a populated word. It sends a command byte with bit 0 set and then a byte with bit 7 set followed by a read in the same frame: a design that opened a data phase after a bad byte would return garbage for the read. Last, it drops chip select part way through a write, where a design that kept its bit count would commit a corrupted word or misframe the next command.

// File: rtl/psh_pkg.sv
package psh_pkg;
   typedef enum logic [2:0] {
      ST_CMD,
      ST_RD_REQ,
      ST_RD_DATA,
      ST_WR_DATA,
      ST_WR_REQ
   } psh_state_e;
endpackage

// File: rtl/psh_sync.sv
module psh_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_depth
      $error("psh_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/psh_ctrl.sv
module psh_ctrl
   import psh_pkg::*;
#(
   parameter int DATA_W = 24,
   parameter int ADDR_W = 5,
   parameter int PAGE_W = 7
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cs_s,
   input  logic                     sclk_s,
   input  logic                     sdi_s,
   output logic                     bus_req,
   output logic                     bus_we,
   output logic [PAGE_W+ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0]        bus_wdata,
   input  logic                     bus_ack,
   input  logic [DATA_W-1:0]        bus_rdata,
   output logic                     sdo_d,
   output logic                     cmd_ok
);
   localparam int CMD_W = ADDR_W + 3;
   localparam int CNT_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] LAST_CMD  = CNT_W'(CMD_W - 1);
   localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_W - 1);
   localparam logic [ADDR_W-1:0] PAGE_SLOT = '1;

   psh_state_e          state_q;
   logic [CNT_W-1:0]    cnt_q;
   logic [DATA_W-1:0]   rx_q, tx_q, rd_buf_q, wdata_q;
   logic [ADDR_W-1:0]   slot_q;
   logic [PAGE_W-1:0]   page_q;
   logic                sclk_q, loaded_q, req_q, we_q, ok_q;

   logic                rise, fall;
   logic [CMD_W-1:0]    cmd_byte;
   logic [DATA_W-1:0]   rx_next;
   logic                cmd_valid, cmd_write;
   logic [ADDR_W-1:0]   cmd_slot;

   assign rise      = sclk_s & ~sclk_q & ~cs_s;
   assign fall      = ~sclk_s & sclk_q & ~cs_s;
   assign rx_next   = {rx_q[DATA_W-2:0], sdi_s};
   assign cmd_byte  = rx_next[CMD_W-1:0];
   assign cmd_valid = ~cmd_byte[CMD_W-1] & ~cmd_byte[0];
   assign cmd_write = cmd_byte[CMD_W-2];
   assign cmd_slot  = cmd_byte[ADDR_W:1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_CMD;
         cnt_q    <= '0;
         rx_q     <= '0;
         tx_q     <= '0;
         rd_buf_q <= '0;
         wdata_q  <= '0;
         slot_q   <= '0;
         page_q   <= '0;
         sclk_q   <= 1'b0;
         loaded_q <= 1'b0;
         req_q    <= 1'b0;
         we_q     <= 1'b0;
         ok_q     <= 1'b1;
      end else begin
         sclk_q <= sclk_s;
         if (cs_s && !req_q) begin
            state_q  <= ST_CMD;
            cnt_q    <= '0;
            loaded_q <= 1'b0;
            tx_q     <= '0;
         end else begin
            unique case (state_q)
               ST_CMD: if (rise) begin
                  rx_q <= rx_next;
                  if (cnt_q == LAST_CMD) begin
                     cnt_q <= '0;
                     if (!cmd_valid) begin
                        ok_q <= 1'b0;
                     end else begin
                        slot_q <= cmd_slot;
                        if (cmd_write) begin
                           state_q <= ST_WR_DATA;
                        end else if (cmd_slot == PAGE_SLOT) begin
                           rd_buf_q <= '0;
                           state_q  <= ST_RD_DATA;
                        end else begin
                           req_q   <= 1'b1;
                           we_q    <= 1'b0;
                           state_q <= ST_RD_REQ;
                        end
                     end
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               ST_RD_REQ: if (bus_ack) begin
                  rd_buf_q <= bus_rdata;
                  req_q    <= 1'b0;
                  state_q  <= ST_RD_DATA;
               end
               ST_RD_DATA: begin
                  if (fall) begin
                     loaded_q <= 1'b1;
                     tx_q     <= loaded_q ? (tx_q << 1) : rd_buf_q;
                  end
                  if (rise) begin
                     if (cnt_q == LAST_DATA) begin
                        cnt_q    <= '0;
                        loaded_q <= 1'b0;
                        tx_q     <= '0;
                        state_q  <= ST_CMD;
                     end else begin
                        cnt_q <= cnt_q + 1'b1;
                     end
                  end
               end
               ST_WR_DATA: if (rise) begin
                  rx_q <= rx_next;
                  if (cnt_q == LAST_DATA) begin
                     cnt_q <= '0;
                     if (slot_q == PAGE_SLOT) begin
                        page_q  <= rx_next[PAGE_W-1:0];
                        state_q <= ST_CMD;
                     end else begin
                        wdata_q <= rx_next;
                        req_q   <= 1'b1;
                        we_q    <= 1'b1;
                        state_q <= ST_WR_REQ;
                     end
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               ST_WR_REQ: if (bus_ack) begin
                  req_q   <= 1'b0;
                  state_q <= ST_CMD;
               end
               default: state_q <= ST_CMD;
            endcase
         end
      end
   end

   assign bus_req   = req_q;
   assign bus_we    = we_q;
   assign bus_addr  = {page_q, slot_q};
   assign bus_wdata = wdata_q;
   assign sdo_d     = tx_q[DATA_W-1];
   assign cmd_ok    = ok_q;
endmodule

// File: rtl/psh_regfile.sv
module psh_regfile #(
   parameter int DATA_W     = 24,
   parameter int ADDR_W     = 5,
   parameter int PAGE_W     = 7,
   parameter int IMPL_PAGES = 2,
   parameter bit RESET_MEM  = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bus_req,
   input  logic                     bus_we,
   input  logic [PAGE_W+ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0]        bus_wdata,
   output logic                     bus_ack,
   output logic [DATA_W-1:0]        bus_rdata
);
   localparam int unsigned SLOTS = (2 ** ADDR_W) - 1;
   localparam int unsigned DEPTH = IMPL_PAGES * SLOTS;

   logic [PAGE_W-1:0] page;
   logic [ADDR_W-1:0] slot;
   logic              present, access;
   int unsigned       idx;
   logic [DATA_W-1:0] words [DEPTH];
   logic              ack_q;
   logic [DATA_W-1:0] rdata_q;

   assign page    = bus_addr[ADDR_W +: PAGE_W];
   assign slot    = bus_addr[ADDR_W-1:0];
   assign present = (32'(page) < IMPL_PAGES) && (slot != '1);
   assign idx     = 32'(page) * SLOTS + 32'(slot);
   assign access  = bus_req & ~ack_q;

   for (genvar w = 0; w < int'(DEPTH); w++) begin : g_word
      logic [DATA_W-1:0] word_q;
      logic              hit;
      assign hit = access & bus_we & present & (idx == unsigned'(w));
      if (RESET_MEM) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   word_q <= '0;
            else if (hit) word_q <= bus_wdata;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (hit) word_q <= bus_wdata;
         end
      end
      assign words[w] = word_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_q   <= 1'b0;
         rdata_q <= '0;
      end else begin
         ack_q <= access;
         if (access) rdata_q <= (present && !bus_we) ? words[idx] : '0;
      end
   end

   assign bus_ack   = ack_q;
   assign bus_rdata = rdata_q;
endmodule

// File: rtl/paged_serial_host_if.sv
module paged_serial_host_if #(
   parameter int DATA_W      = 24,
   parameter int ADDR_W      = 5,
   parameter int PAGE_W      = 7,
   parameter int IMPL_PAGES  = 2,
   parameter int SYNC_STAGES = 2,
   parameter bit RESET_MEM   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic sclk,
   input  logic sdi,
   output logic sdo,
   output logic sdo_oe,
   output logic cmd_ok
);
   localparam int BUS_AW = PAGE_W + ADDR_W;

   if (DATA_W % 8 != 0) begin : g_chk_bytes
      $error("DATA_W must be a whole number of bytes");
   end
   if (DATA_W < ADDR_W + 3) begin : g_chk_cmd
      $error("DATA_W too narrow for the command byte");
   end
   if (IMPL_PAGES < 1 || IMPL_PAGES > 2 ** PAGE_W) begin : g_chk_pages
      $error("IMPL_PAGES out of range");
   end

   logic cs_s, sclk_s, sdi_s;
   logic bus_req, bus_we, bus_ack;
   logic [BUS_AW-1:0] bus_addr;
   logic [DATA_W-1:0] bus_wdata, bus_rdata;
   logic sdo_d;

   psh_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
      .clk(clk), .rst_n(rst_n), .d(cs_n), .q(cs_s));
   psh_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sclk_sync (
      .clk(clk), .rst_n(rst_n), .d(sclk), .q(sclk_s));
   psh_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sdi_sync (
      .clk(clk), .rst_n(rst_n), .d(sdi), .q(sdi_s));

   psh_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cs_s(cs_s), .sclk_s(sclk_s), .sdi_s(sdi_s),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
      .sdo_d(sdo_d), .cmd_ok(cmd_ok));

   psh_regfile #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W),
      .IMPL_PAGES(IMPL_PAGES), .RESET_MEM(RESET_MEM)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata));

   assign sdo_oe = ~cs_n;
   assign sdo    = sdo_d;
endmodule

// File: rtl/psh_checker.sv
module psh_checker #(
   parameter int ADDR_W = 5,
   parameter int PAGE_W = 7
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     bus_req,
   input logic                     bus_we,
   input logic                     bus_ack,
   input logic [PAGE_W+ADDR_W-1:0] bus_addr,
   input logic                     cmd_ok
);
   // The page pointer lives in the serial logic; slot 31 never reaches the array.
   assert_page_slot_local_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> (bus_addr[ADDR_W-1:0] != '1));

   // A request holds with a fixed address and direction until it is acknowledged.
   assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

   // The array acknowledges only an outstanding request.
   assert_ack_has_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ack |-> bus_req);

   // Once cleared, the framing status stays cleared until reset.
   assert_status_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_ok |=> !cmd_ok);
endmodule

bind paged_serial_host_if psh_checker #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
   .bus_ack(bus_ack), .bus_addr(bus_addr), .cmd_ok(cmd_ok));

// File: tb/paged_serial_host_if_tb_top.sv
module paged_serial_host_if_tb_top;
   localparam int HALF = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1;
   logic sclk = 1'b0;
   logic sdi = 1'b0;
   logic sdo, sdo_oe, cmd_ok;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [23:0] exp_q[$];
   logic [23:0] got_q[$];
   string       tag_q[$];

   always #10 clk = ~clk;

   paged_serial_host_if dut_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
      .sdo(sdo), .sdo_oe(sdo_oe), .cmd_ok(cmd_ok));

   task automatic check(input bit ok, input string req, input logic [23:0] act,
                        input logic [23:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic xfer_bit(input logic b, output logic got);
      sdi = b;
      repeat (HALF) @(negedge clk);
      got  = sdo;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] b);
      logic dummy;
      for (int i = 7; i >= 0; i--) xfer_bit(b[i], dummy);
   endtask

   task automatic frame_open();
      cs_n = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic frame_close();
      repeat (4) @(negedge clk);
      cs_n = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   // R1 command format: bit7=0, bit6=write, bits5:1 slot, bit0=0
   task automatic wr(input logic [4:0] slot, input logic [23:0] data);
      logic dummy;
      send_byte({2'b01, slot, 1'b0});
      for (int i = 23; i >= 0; i--) xfer_bit(data[i], dummy);
   endtask

   task automatic rd(input logic [4:0] slot, input logic [23:0] exp, input string tag);
      logic [23:0] got;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      send_byte({2'b00, slot, 1'b0});
      for (int i = 23; i >= 0; i--) xfer_bit(1'b0, got[i]);
      got_q.push_back(got);
   endtask

   task automatic set_page(input logic [6:0] p);
      wr(5'd31, {17'd0, p});
   endtask

   // scoreboard monitor
   initial begin
      forever begin
         logic [23:0] g, e;
         string t;
         wait (got_q.size() != 0);
         g = got_q.pop_front();
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         check(g === e, t, g, e);
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      check(cmd_ok === 1'b1, "R7 reset status", 24'(cmd_ok), 24'd1);
      check(sdo_oe === 1'b0, "R8 idle oe", 24'(sdo_oe), 24'd0);

      // R5: default page is 0
      frame_open();
      check(sdo_oe === 1'b1, "R8 oe in frame", 24'(sdo_oe), 24'd1);
      wr(5'd0, 24'hA5C3E1);
      wr(5'd30, 24'h123456);
      rd(5'd30, 24'h123456, "R2 R3 slot30 readback");
      set_page(7'd1);
      rd(5'd0, 24'h000000, "R5 page1 fresh slot0");
      wr(5'd0, 24'h5A5A5A);
      rd(5'd0, 24'h5A5A5A, "R4 page1 slot0");
      rd(5'd31, 24'h000000, "R6 page pointer reads zero");
      set_page(7'd0);
      rd(5'd0, 24'hA5C3E1, "R5 R4 page0 slot0 kept");
      frame_close();
      check(sdo_oe === 1'b0, "R8 oe after frame", 24'(sdo_oe), 24'd0);

      // R9: unpopulated page
      frame_open();
      set_page(7'd5);
      wr(5'd0, 24'hFFFFFF);
      rd(5'd0, 24'h000000, "R9 unpopulated read zero");
      set_page(7'd127);
      wr(5'd30, 24'hC0FFEE);
      rd(5'd30, 24'h000000, "R9 top page read zero");
      set_page(7'd0);
      rd(5'd0, 24'hA5C3E1, "R9 page0 slot0 untouched");
      rd(5'd30, 24'h123456, "R9 page0 slot30 untouched");
      frame_close();

      // R1: back-to-back pattern
      frame_open();
      wr(5'd1, 24'hAAAAAA);
      rd(5'd1, 24'hAAAAAA, "R1 back-to-back alt pattern");
      wr(5'd1, 24'h800001);
      rd(5'd1, 24'h800001, "R1 R3 edge bits");
      frame_close();

      // R7: invalid command bytes
      frame_open();
      send_byte(8'h03);
      check(cmd_ok === 1'b0, "R7 bit0 set clears status", 24'(cmd_ok), 24'd0);
      send_byte(8'h80);
      rd(5'd30, 24'h123456, "R7 next byte is a command");
      check(cmd_ok === 1'b0, "R7 status sticky", 24'(cmd_ok), 24'd0);
      frame_close();

      // R8: abort a write with chip select
      frame_open();
      begin
         logic dummy;
         send_byte({2'b01, 5'd30, 1'b0});
         for (int i = 0; i < 10; i++) xfer_bit(1'b1, dummy);
      end
      frame_close();
      frame_open();
      rd(5'd30, 24'h123456, "R8 aborted write discarded");
      frame_close();

      wait (got_q.size() == 0);
      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule